// File: doc/BRIEF.md
# SPI master transfer controller

This block is the master end of a four-wire serial link. It exchanges one word at a time, full duplex, with a single peripheral. The host presents a word on `tx_byte_i` and pulses `start_i`. Along with the word it supplies the clock polarity, the clock phase, the bit order, a baud divisor `D` and a settle count `W`. The controller then does four things in turn. It pulls the active-low select `cs_n_o` low. It waits out the settle time. It produces eight SCLK pulses derived from the system clock, shifting MOSI out and sampling MISO on edges that depend on the mode. Finally it returns the received word on `rx_byte_o` with a one-cycle `done_o` pulse.

Setting `stream_i` with a start keeps the select low once that word has finished. The host can then chain further words without the select dropping and without repeating the settle wait. The select is released after the first word that is started with `stream_i` low. Configuration is taken when a start is accepted. Polarity and phase are fixed for the whole time the select stays low.

Top module: `spi_xfer_master`

## Requirements
- R1: During and after reset `cs_n_o` is 1, `busy_o` is 0 and `done_o` is 0. While idle, `sclk_o` equals `cpol_i` from the first cycle after reset onward.
- R2: A start accepted while idle drives `cs_n_o` low in the next cycle. SCLK stays at its idle level until the first SCLK edge. That edge comes exactly W+D+2 system clocks after `cs_n_o` falls, where W is `settle_i` and D is `baud_div_i`.
- R3: Every SCLK half period lasts D+1 system clocks. With D=0, SCLK toggles on every system clock.
- R4: The idle SCLK level equals CPOL. Leading edges are those that leave the idle level. With CPHA=0, MISO is sampled on leading edges and MOSI changes on trailing edges. With CPHA=1, MOSI changes on leading edges and MISO is sampled on trailing edges. Each word takes exactly 8 pulses (16 edges) and ends with SCLK at the idle level.
- R5: With `lsb_first_i`=0, bit 7 of `tx_byte_i` is sent first. Each received bit enters at bit 0, so the first received bit ends up in bit 7 of `rx_byte_o`.
- R6: With `lsb_first_i`=1, bit 0 is sent first. Received bits enter at bit 7 and move down, so the first received bit ends up in bit 0.
- R7: `done_o` is high for exactly one system clock, one clock after the 16th SCLK edge. In that same cycle `rx_byte_o` takes the received word, and it holds that value until the next `done_o`.
- R8: For a word started with `stream_i`=0, `cs_n_o` returns high in the same cycle as `done_o`, with SCLK already at the idle level.
- R9: For a word started with `stream_i`=1, `cs_n_o` stays low after `done_o` and SCLK stays idle. A following start begins clocking D+1 clocks after it is accepted, with no settle wait.
- R10: `busy_o` is high from the cycle after an accepted start until the `done_o` cycle, when it is low. A `start_i` that arrives while busy is ignored: it produces no extra word and changes no setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe for one word |
| stream_i | input | 1 | Keep the select low after this word |
| tx_byte_i | input | WIDTH | Word to send |
| cpol_i | input | 1 | Idle level of SCLK |
| cpha_i | input | 1 | 0: sample on leading edges, 1: sample on trailing edges |
| lsb_first_i | input | 1 | Send and receive bit 0 first |
| baud_div_i | input | DIV_W | Half period minus one, in system clocks |
| settle_i | input | WAIT_W | Extra wait between select and first edge |
| miso_i | input | 1 | Serial data from the peripheral |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to the peripheral |
| cs_n_o | output | 1 | Active-low select |
| rx_byte_o | output | WIDTH | Received word |
| done_o | output | 1 | One-cycle end-of-word pulse |
| busy_o | output | 1 | Word in progress |

## Verification
Each result has a fixed arrival cycle:
- the select falls one clock after the start;
- the first SCLK edge follows the select fall by W+D+2 clocks, or follows the start by D+1 clocks when the select is already held;
- later edges come every D+1 clocks;
- `done_o`, the received word and the select release all appear one clock after the 16th edge.

A monitor samples on the falling system clock edge. It stamps each of these events with a cycle number and plays the peripheral, driving MISO and capturing MOSI according to the mode. The checks compare the cycle differences and the captured words against these formulas, rather than polling until a value happens to appear.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_WAIT = 3'd1,
        ST_XFER = 3'd2,
        ST_LAST = 3'd3,
        ST_HOLD = 3'd4
    } xfer_state_e;

endpackage

// File: rtl/spi_half_tick.sv
module spi_half_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);

    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run_i) begin
            cnt_d = '0;
        end else if (cnt_q == div_i) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign tick_o = run_i && (cnt_q == div_i);

    // R3: two ticks in a row only when the divisor is zero
    assert_back_to_back_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && $past(tick_o) && $past(run_i) && ($past(div_i) == div_i)) |-> (div_i == '0));

    // R3: the running count never passes the divisor
    assert_count_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && $past(run_i)) |-> (cnt_q <= div_i));

endmodule

// File: rtl/spi_word_shifter.sv
module spi_word_shifter #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [WIDTH-1:0] load_word_i,
    input  logic             lsb_first_i,
    input  logic             shift_i,
    input  logic             sample_i,
    input  logic             miso_i,
    output logic             mosi_o,
    output logic [WIDTH-1:0] rx_word_o
);

    typedef struct packed {
        logic [WIDTH-1:0] tx;
        logic [WIDTH-1:0] rx;
    } shreg_t;

    shreg_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load_i) begin
            sh_d.tx = load_word_i;
            sh_d.rx = '0;
        end else begin
            if (shift_i) begin
                sh_d.tx = lsb_first_i ? (sh_q.tx >> 1) : (sh_q.tx << 1);
            end
            if (sample_i) begin
                sh_d.rx = lsb_first_i ? {miso_i, sh_q.rx[WIDTH-1:1]}
                                      : {sh_q.rx[WIDTH-2:0], miso_i};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign mosi_o    = lsb_first_i ? sh_q.tx[0] : sh_q.tx[WIDTH-1];
    assign rx_word_o = sh_q.rx;

    // R4: an edge either moves MOSI or samples MISO, never both
    assert_no_shift_on_sample_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(shift_i && sample_i));

    // R5: a new word is loaded only between edges
    assert_load_alone_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> (!shift_i && !sample_i));

endmodule

// File: rtl/spi_xfer_master.sv
module spi_xfer_master
    import spi_xfer_pkg::*;
#(
    parameter int WIDTH  = 8,
    parameter int DIV_W  = 8,
    parameter int WAIT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              stream_i,
    input  logic [WIDTH-1:0]  tx_byte_i,
    input  logic              cpol_i,
    input  logic              cpha_i,
    input  logic              lsb_first_i,
    input  logic [DIV_W-1:0]  baud_div_i,
    input  logic [WAIT_W-1:0] settle_i,
    input  logic              miso_i,
    output logic              sclk_o,
    output logic              mosi_o,
    output logic              cs_n_o,
    output logic [WIDTH-1:0]  rx_byte_o,
    output logic              done_o,
    output logic              busy_o
);

    localparam int EDGES  = 2 * WIDTH;
    localparam int EDGE_W = $clog2(EDGES);
    localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(EDGES - 1);

    typedef struct packed {
        xfer_state_e       st;
        logic              cs_n;
        logic              sclk;
        logic              cpol;
        logic              cpha;
        logic              lsb;
        logic              stream;
        logic [DIV_W-1:0]  div;
        logic [WAIT_W-1:0] wcnt;
        logic [EDGE_W-1:0] edge_idx;
        logic              done;
        logic [WIDTH-1:0]  rx_out;
    } ctl_t;

    localparam ctl_t CTL_RST = '{
        st:       ST_IDLE,
        cs_n:     1'b1,
        sclk:     1'b0,
        cpol:     1'b0,
        cpha:     1'b0,
        lsb:      1'b0,
        stream:   1'b0,
        div:      '0,
        wcnt:     '0,
        edge_idx: '0,
        done:     1'b0,
        rx_out:   '0
    };

    ctl_t ctl_d, ctl_q;

    logic             tick;
    logic             run;
    logic             accept;
    logic             sample_en;
    logic             shift_en;
    logic [WIDTH-1:0] rx_word;

    assign run    = (ctl_q.st == ST_XFER);
    assign accept = start_i && ((ctl_q.st == ST_IDLE) || (ctl_q.st == ST_HOLD));

    // Even edge index = leading edge. CPHA picks which parity samples.
    assign sample_en = tick && (ctl_q.edge_idx[0] == ctl_q.cpha);
    assign shift_en  = tick && (ctl_q.edge_idx[0] != ctl_q.cpha) &&
                       !(ctl_q.cpha ? (ctl_q.edge_idx == '0) : (ctl_q.edge_idx == LAST_EDGE));

    spi_half_tick #(
        .DIV_W (DIV_W)
    ) u_half_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .div_i  (ctl_q.div),
        .tick_o (tick)
    );

    spi_word_shifter #(
        .WIDTH (WIDTH)
    ) u_shifter (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (accept),
        .load_word_i (tx_byte_i),
        .lsb_first_i (ctl_q.lsb),
        .shift_i     (shift_en),
        .sample_i    (sample_en),
        .miso_i      (miso_i),
        .mosi_o      (mosi_o),
        .rx_word_o   (rx_word)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                ctl_d.cpol = cpol_i;
                ctl_d.cpha = cpha_i;
                ctl_d.sclk = cpol_i;
                if (accept) begin
                    ctl_d.cs_n     = 1'b0;
                    ctl_d.lsb      = lsb_first_i;
                    ctl_d.stream   = stream_i;
                    ctl_d.div      = baud_div_i;
                    ctl_d.wcnt     = settle_i;
                    ctl_d.edge_idx = '0;
                    ctl_d.st       = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (ctl_q.wcnt == '0) begin
                    ctl_d.st = ST_XFER;
                end else begin
                    ctl_d.wcnt = ctl_q.wcnt - 1'b1;
                end
            end
            ST_XFER: begin
                if (tick) begin
                    ctl_d.sclk     = ~ctl_q.sclk;
                    ctl_d.edge_idx = ctl_q.edge_idx + 1'b1;
                    if (ctl_q.edge_idx == LAST_EDGE) begin
                        ctl_d.st = ST_LAST;
                    end
                end
            end
            ST_LAST: begin
                ctl_d.done   = 1'b1;
                ctl_d.rx_out = rx_word;
                if (ctl_q.stream) begin
                    ctl_d.st = ST_HOLD;
                end else begin
                    ctl_d.cs_n = 1'b1;
                    ctl_d.st   = ST_IDLE;
                end
            end
            ST_HOLD: begin
                if (accept) begin
                    ctl_d.lsb      = lsb_first_i;
                    ctl_d.stream   = stream_i;
                    ctl_d.div      = baud_div_i;
                    ctl_d.edge_idx = '0;
                    ctl_d.st       = ST_XFER;
                end
            end
            default: begin
                ctl_d = CTL_RST;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= CTL_RST;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign sclk_o    = ctl_q.sclk;
    assign cs_n_o    = ctl_q.cs_n;
    assign done_o    = ctl_q.done;
    assign rx_byte_o = ctl_q.rx_out;
    assign busy_o    = (ctl_q.st == ST_WAIT) || (ctl_q.st == ST_XFER) || (ctl_q.st == ST_LAST);

    // R2: SCLK moves outside idle only while the select is low
    assert_clock_only_when_selected_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(ctl_q.sclk) && ($past(ctl_q.st) != ST_IDLE)) |-> !ctl_q.cs_n);

    // R2: no SCLK edge during the settle wait
    assert_wait_before_clock_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ctl_q.st) == ST_WAIT) |-> $stable(ctl_q.sclk));

    // R4: a word ends with SCLK at its idle level
    assert_idle_at_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.done |-> (ctl_q.sclk == ctl_q.cpol));

    // R7: done lasts a single cycle
    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.done |=> !ctl_q.done);

    // R8: the select is released only together with done
    assert_release_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_q.cs_n) |-> ctl_q.done);

    // R9: a held stream keeps the select low
    assert_stream_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_HOLD) |-> !ctl_q.cs_n);

    // R10: busy is already low in the done cycle
    assert_busy_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.done |-> !busy_o);

    // R10: a start during clocking does not restart the word
    assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && (ctl_q.st == ST_XFER)) |=> ((ctl_q.st == ST_XFER) || (ctl_q.st == ST_LAST)));

endmodule

// File: tb/tb_spi_xfer_master.sv
`timescale 1ns/1ps
module tb_spi_xfer_master;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       stream = 1'b0;
    logic [7:0] tx = 8'h00;
    logic       cpol = 1'b0;
    logic       cpha = 1'b0;
    logic       lsb = 1'b0;
    logic [7:0] div = 8'd0;
    logic [7:0] settle = 8'd0;
    logic       miso = 1'b0;
    logic       sclk, mosi, cs_n, done, busy;
    logic [7:0] rx;

    always #2 clk = ~clk;

    spi_xfer_master #(.WIDTH(8), .DIV_W(8), .WAIT_W(8)) dut (
        .clk (clk), .rst_n (rst_n), .start_i (start), .stream_i (stream),
        .tx_byte_i (tx), .cpol_i (cpol), .cpha_i (cpha), .lsb_first_i (lsb),
        .baud_div_i (div), .settle_i (settle), .miso_i (miso),
        .sclk_o (sclk), .mosi_o (mosi), .cs_n_o (cs_n), .rx_byte_o (rx),
        .done_o (done), .busy_o (busy)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // monitor and peripheral model state
    int cyc = 0, busy_rise_cyc = 0, cs_fall_cyc = 0, first_edge_cyc = 0;
    int prev_edge_cyc = 0, last_edge_cyc = 0, done_cyc = 0;
    int edge_cnt = 0, edges_at_done = 0, done_cnt = 0, cs_rise_cnt = 0;
    bit half_bad = 0, done_wide = 0;
    logic sclk_prev = 1'b0, cs_prev = 1'b1, busy_prev = 1'b0, done_prev = 1'b0;
    logic [7:0] rx_at_done = 8'h00;
    logic cs_at_done = 1'b1, busy_at_done = 1'b0, sclk_at_done = 1'b0;
    logic [7:0] slave_bytes [4];
    logic [7:0] model_rx [4];
    logic [7:0] mbyte = 8'h00, mcap = 8'h00;
    int sidx = 0, k = 0, scnt = 0;

    function automatic logic mbit(input logic [7:0] b, input int kk, input logic l);
        if (kk > 7) return 1'b0;
        return l ? b[kk] : b[7-kk];
    endfunction

    always @(negedge clk) begin
        cyc++;
        if (cyc >= 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
        if (rst_n) begin
            if (busy && !busy_prev) begin
                busy_rise_cyc = cyc;
                edge_cnt = 0;
                half_bad = 0;
            end
            if (!cs_n && cs_prev) begin
                cs_fall_cyc = cyc;
                sidx = 0; k = 0; scnt = 0; mcap = 8'h00;
                mbyte = slave_bytes[0];
                if (!cpha) miso = mbit(mbyte, 0, lsb);
            end
            if (cs_n && !cs_prev) cs_rise_cnt++;
            if (sclk != sclk_prev) begin
                edge_cnt++;
                if (edge_cnt == 1) first_edge_cyc = cyc;
                if (edge_cnt >= 2 && (cyc - prev_edge_cyc) != int'(div) + 1) half_bad = 1;
                prev_edge_cyc = cyc;
                last_edge_cyc = cyc;
                if ((sclk != cpol) != cpha) begin
                    // sampling edge of the peripheral
                    mcap = lsb ? {mosi, mcap[7:1]} : {mcap[6:0], mosi};
                    scnt++;
                    if (cpha && scnt == 8) begin
                        model_rx[sidx] = mcap;
                        if (sidx < 3) sidx++;
                        mbyte = slave_bytes[sidx];
                        k = 0; scnt = 0;
                    end
                end else begin
                    // driving edge of the peripheral
                    if (!cpha) begin
                        if (scnt == 8) begin
                            model_rx[sidx] = mcap;
                            if (sidx < 3) sidx++;
                            mbyte = slave_bytes[sidx];
                            k = 0; scnt = 0;
                        end else begin
                            k++;
                        end
                        miso = mbit(mbyte, k, lsb);
                    end else begin
                        miso = mbit(mbyte, k, lsb);
                        k++;
                    end
                end
            end
            if (done) begin
                done_cnt++;
                done_cyc = cyc;
                rx_at_done = rx;
                cs_at_done = cs_n;
                busy_at_done = busy;
                sclk_at_done = sclk;
                edges_at_done = edge_cnt;
                if (done_prev) done_wide = 1;
            end
        end
        sclk_prev = sclk;
        cs_prev = cs_n;
        busy_prev = busy;
        done_prev = done;
    end

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input int n0);
        for (int i = 0; i < 20000 && done_cnt <= n0; i++) @(negedge clk);
        if (done_cnt <= n0) chk("R7", "done never seen", done_cnt, n0 + 1);
    endtask

    task automatic t_reset();
        chk("R1", "cs_n in reset", cs_n, 1);
        chk("R1", "busy in reset", busy, 0);
        chk("R1", "done in reset", done, 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1", "sclk idle after reset cpol=0", sclk, 0);
        cpol = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1", "sclk idle follows cpol=1", sclk, 1);
        chk("R1", "cs_n idle", cs_n, 1);
        cpol = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_single(input logic p, input logic h, input logic l, input int d,
                            input int w, input logic [7:0] t, input logic [7:0] s);
        int n0;
        string otag;
        otag = l ? "R6" : "R5";
        cpol = p; cpha = h; lsb = l; div = 8'(d); settle = 8'(w); tx = t; stream = 1'b0;
        slave_bytes[0] = s;
        repeat (2) @(negedge clk);
        chk("R4", "idle level before word", sclk, p);
        n0 = done_cnt;
        pulse_start();
        wait_done(n0);
        repeat (2) @(negedge clk);
        chk(otag, "received word", rx_at_done, s);
        chk(otag, "word seen by peripheral", model_rx[0], t);
        chk("R2", "select falls with busy", cs_fall_cyc, busy_rise_cyc);
        chk("R2", "select to first edge", first_edge_cyc - cs_fall_cyc, w + d + 2);
        chk("R3", "half period", half_bad, 0);
        chk("R4", "edges per word", edges_at_done, 16);
        chk("R7", "done after last edge", done_cyc - last_edge_cyc, 1);
        chk("R7", "done width", done_wide, 0);
        chk("R7", "word held after done", rx, s);
        chk("R8", "select released at done", cs_at_done, 1);
        chk("R8", "sclk idle at done", sclk_at_done, p);
        chk("R10", "busy low at done", busy_at_done, 0);
    endtask

    task automatic t_stream(input logic p, input logic h, input logic l, input int d);
        logic [7:0] txs [3];
        logic [7:0] got [3];
        int rise0, n0;
        txs[0] = 8'h5A; txs[1] = 8'hC3; txs[2] = 8'h0F;
        slave_bytes[0] = 8'h96; slave_bytes[1] = 8'h21; slave_bytes[2] = 8'hE8;
        slave_bytes[3] = 8'h00;
        cpol = p; cpha = h; lsb = l; div = 8'(d); settle = 8'd3;
        repeat (2) @(negedge clk);
        rise0 = cs_rise_cnt;
        for (int b = 0; b < 3; b++) begin
            tx = txs[b];
            stream = (b < 2);
            n0 = done_cnt;
            pulse_start();
            wait_done(n0);
            got[b] = rx_at_done;
            if (b == 1) chk("R9", "held start to first edge", first_edge_cyc - busy_rise_cyc, d + 1);
            if (b < 2) begin
                chk("R9", "select held at done", cs_at_done, 0);
                repeat (3) @(negedge clk);
                chk("R9", "select low between words", cs_n, 0);
                chk("R9", "sclk idle between words", sclk, p);
                chk("R10", "not busy while held", busy, 0);
            end
        end
        repeat (2) @(negedge clk);
        chk("R8", "last word releases select", cs_at_done, 1);
        chk("R9", "single select release in stream", cs_rise_cnt - rise0, 1);
        for (int b = 0; b < 3; b++) begin
            chk(l ? "R6" : "R5", "stream word received", got[b], slave_bytes[b]);
            chk(l ? "R6" : "R5", "stream word sent", model_rx[b], txs[b]);
        end
        stream = 1'b0;
    endtask

    task automatic t_busy_ignore();
        int n0;
        cpol = 1'b0; cpha = 1'b0; lsb = 1'b0; div = 8'd4; settle = 8'd1;
        tx = 8'h3C; stream = 1'b0;
        slave_bytes[0] = 8'hA7; slave_bytes[1] = 8'h11;
        repeat (2) @(negedge clk);
        n0 = done_cnt;
        pulse_start();
        repeat (20) @(negedge clk);
        chk("R10", "busy during word", busy, 1);
        tx = 8'hFF; stream = 1'b1; lsb = 1'b1; div = 8'd0;
        pulse_start();
        tx = 8'h00; stream = 1'b0; lsb = 1'b0; div = 8'd4;
        wait_done(n0);
        repeat (40) @(negedge clk);
        chk("R10", "one word only", done_cnt, n0 + 1);
        chk("R10", "first word kept", model_rx[0], 8'h3C);
        chk("R10", "received word", rx_at_done, 8'hA7);
        chk("R10", "half period unchanged", half_bad, 0);
        chk("R10", "stream request ignored", cs_n, 1);
        chk("R10", "idle after word", busy, 0);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin
            slave_bytes[i] = 8'h00;
            model_rx[i] = 8'h00;
        end
        repeat (3) @(negedge clk);
        t_reset();
        t_single(1'b0, 1'b0, 1'b0, 1, 2, 8'hA5, 8'h3B);
        t_single(1'b0, 1'b1, 1'b1, 0, 0, 8'h81, 8'h4E);
        t_single(1'b1, 1'b0, 1'b0, 3, 5, 8'h12, 8'hF0);
        t_single(1'b1, 1'b1, 1'b1, 2, 1, 8'hE7, 8'h09);
        t_single(1'b0, 1'b0, 1'b1, 0, 7, 8'h01, 8'h80);
        t_stream(1'b0, 1'b1, 1'b0, 1);
        t_stream(1'b1, 1'b0, 1'b1, 2);
        t_busy_ignore();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule